// File: doc/BRIEF.md
# SCSI End-of-Process and Bus-Reset Interrupt Logic

This block is the interrupt and status part of a SCSI bus controller. It watches two sources. The first is the end-of-process strobe of a DMA block transfer. The strobe counts only when the controller is in DMA mode and the strobe overlaps the DMA acknowledge and a read or write strobe for a minimum number of clock cycles. A strobe that counts sets a sticky end-of-DMA status bit and, if the mode enable allows it, raises the interrupt. The second source is a bus reset. It comes either from the SCSI RST line going active or from software setting the assert-reset command bit. A bus reset always raises the interrupt, whatever the enables say. It also forces a bus-release output that makes the controller let go of every bus signal it drives for a bus-clear interval.

The block also presents two read-only byte views for the register decoder. The first is the bus-and-status byte. The second is the current-bus-status byte, which shows the synchronized bus lines as they are now; the RST bit is never held.

There are two state machines. The overlap qualifier has the states `EQ_IDLE`, `EQ_COUNT` and `EQ_HIT`:
- `EQ_IDLE` moves to `EQ_COUNT` when the overlap appears.
- `EQ_COUNT` moves to `EQ_HIT` when the count is reached, and back to `EQ_IDLE` when any qualifying strobe drops.
- `EQ_HIT` moves back to `EQ_IDLE` when the overlap ends.

The reset monitor has the states `RM_IDLE`, `RM_CLEAR` and `RM_HOLD`:
- Any new reset edge moves the monitor to `RM_CLEAR` from every state.
- `RM_CLEAR` moves to `RM_HOLD` when its interval ends with the reset still active, and to `RM_IDLE` when the reset is gone.
- `RM_HOLD` moves to `RM_IDLE` once the reset goes inactive.

Top module: `scsi_irq_status`

## Requirements
- R1: In DMA mode, an overlap of end-of-process, acknowledge and read-or-write (all active low) for `OVL_CYC` consecutive clock edges (default 10) sets `end_of_dma`, which then stays set.
- R2: An overlap shorter than `OVL_CYC` edges, or one seen outside DMA mode, leaves `end_of_dma` clear.
- R3: A recognized end-of-process raises `irq` only while `eop_irq_en` is 1.
- R4: `end_of_dma` is cleared on the clock edge after `dma_mode` is seen low.
- R5: A high-to-low transition of `bus_rst_n` raises `irq` even when `eop_irq_en` is 0.
- R6: A 0-to-1 transition of `sw_rst` raises `irq`.
- R7: `bus_release` is 1 from the first edge that sees a reset transition. It stays 1 for `CLEAR_CYC` edges (default 160), and for as long as either reset source stays active. It then returns to 0.
- R8: `irq` stays 1 until `irq_clear` is sampled at 1. When a new interrupt source and `irq_clear` arrive on the same edge, the new source wins.
- R9: `bus_stat` bits 7..0 are end_of_dma, dma_req, parity_err, irq, phase_match, busy_err, ATN asserted, ACK asserted. Each bit reads 1 when its condition is true.
- R10: `cur_bus` bits 7..0 are RST, BSY, REQ, MSG, C/D, I/O, SEL, DBP. Each bit reads 1 when its line is low. The RST bit follows the live `bus_rst_n` without latching.
- R11: After reset, `irq`, `end_of_dma` and `bus_release` are 0.
- R12: The overlap count restarts whenever any qualifying strobe drops, so two short overlaps never add up to a recognized end-of-process.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_mode | input | 1 | DMA mode flag |
| eop_irq_en | input | 1 | End-of-process interrupt enable |
| sw_rst | input | 1 | Software assert-reset command bit |
| irq_clear | input | 1 | Clear-interrupt strobe |
| eop_n | input | 1 | End-of-process strobe, active low |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_rst_n | input | 1 | SCSI RST line, active low |
| bsy_n | input | 1 | SCSI BSY line, active low |
| req_n | input | 1 | SCSI REQ line, active low |
| msg_n | input | 1 | SCSI MSG line, active low |
| cd_n | input | 1 | SCSI C/D line, active low |
| io_n | input | 1 | SCSI I/O line, active low |
| sel_n | input | 1 | SCSI SEL line, active low |
| dbp_n | input | 1 | SCSI data parity line, active low |
| atn_n | input | 1 | SCSI ATN line, active low |
| ack_n | input | 1 | SCSI ACK line, active low |
| dma_req | input | 1 | DMA request status from the transfer engine |
| parity_err | input | 1 | Parity error status |
| phase_match | input | 1 | Phase match status |
| busy_err | input | 1 | Busy error status |
| irq | output | 1 | Interrupt request |
| end_of_dma | output | 1 | End-of-DMA status |
| bus_release | output | 1 | Release all driven bus signals |
| bus_stat | output | 8 | Bus-and-status byte view |
| cur_bus | output | 8 | Current-bus-status byte view |

## Verification
The bench tests the overlap at the exact limit: `OVL_CYC` edges must count and `OVL_CYC-1` edges must not. A qualifier with an off-by-one error would either set the status on a pulse one cycle short or miss a pulse of legal length. Two short overlaps separated by a one-cycle drop of acknowledge are also applied. A counter that pauses instead of restarting would wrongly set `end_of_dma` on that pattern. The bench drops the enable and checks that a bus reset still raises `irq`, which catches logic that masks the reset source. It raises a new interrupt on the same edge as `irq_clear`, which catches a design that lets the clear win. It checks `bus_release` for both a short reset pulse and a long held reset. A design that only follows the line, or only runs the timer, fails one of the two cases.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;

    typedef enum logic [1:0] {
        EQ_IDLE,
        EQ_COUNT,
        EQ_HIT
    } eop_state_t;

    typedef enum logic [1:0] {
        RM_IDLE,
        RM_CLEAR,
        RM_HOLD
    } rm_state_t;

    // Bit positions in the bus-and-status byte
    localparam int BS_EOD    = 7;
    localparam int BS_DREQ   = 6;
    localparam int BS_PERR   = 5;
    localparam int BS_IRQ    = 4;
    localparam int BS_PMATCH = 3;
    localparam int BS_BERR   = 2;
    localparam int BS_ATN    = 1;
    localparam int BS_ACK    = 0;

    // Bit positions in the current-bus-status byte
    localparam int CB_RST = 7;
    localparam int CB_BSY = 6;
    localparam int CB_REQ = 5;
    localparam int CB_MSG = 4;
    localparam int CB_CD  = 3;
    localparam int CB_IO  = 2;
    localparam int CB_SEL = 1;
    localparam int CB_DBP = 0;

endpackage

// File: rtl/scsi_eop_qual.sv
module scsi_eop_qual
    import scsi_irq_pkg::*;
#(
    parameter int OVL_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_mode,
    input  logic eop_n,
    input  logic dack_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic hit
);

    localparam int CW = $clog2(OVL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(OVL_CYC - 1);

    eop_state_t    state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          ovl;

    assign ovl = dma_mode & ~eop_n & ~dack_n & (~rd_n | ~wr_n);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= EQ_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Next state: any dropped strobe restarts the count (R12)
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            EQ_IDLE: begin
                if (ovl) begin
                    if (OVL_CYC <= 1) begin
                        state_nxt = EQ_HIT;
                    end else begin
                        state_nxt = EQ_COUNT;
                        cnt_nxt   = CW'(1);
                    end
                end
            end
            EQ_COUNT: begin
                if (!ovl) begin
                    state_nxt = EQ_IDLE;
                    cnt_nxt   = '0;
                end else if (cnt == LAST) begin
                    state_nxt = EQ_HIT;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            EQ_HIT: begin
                if (!ovl) state_nxt = EQ_IDLE;
            end
            default: begin
                state_nxt = EQ_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // Output: one-cycle pulse on entry to EQ_HIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= (state != EQ_HIT) && (state_nxt == EQ_HIT);
    end

    a_r2_hit_needs_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(ovl));

    a_r12_drop_blocks_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl |=> !hit);

endmodule

// File: rtl/scsi_rst_mon.sv
module scsi_rst_mon
    import scsi_irq_pkg::*;
#(
    parameter int CLEAR_CYC = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst_n,
    input  logic sw_rst,
    output logic rst_evt,
    output logic release_o
);

    localparam int CW = $clog2(CLEAR_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CLEAR_CYC - 1);

    rm_state_t     state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          bus_prev_n, sw_prev;
    logic          rise, act;

    assign act  = ~bus_rst_n | sw_rst;
    assign rise = (~bus_rst_n & bus_prev_n) | (sw_rst & ~sw_prev);

    // State register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= RM_IDLE;
            cnt        <= '0;
            bus_prev_n <= 1'b1;
            sw_prev    <= 1'b0;
        end else begin
            state      <= state_nxt;
            cnt        <= cnt_nxt;
            bus_prev_n <= bus_rst_n;
            sw_prev    <= sw_rst;
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (rise) begin
            state_nxt = RM_CLEAR;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                RM_IDLE: begin
                    cnt_nxt = '0;
                end
                RM_CLEAR: begin
                    if (cnt == LAST) begin
                        state_nxt = act ? RM_HOLD : RM_IDLE;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + CW'(1);
                    end
                end
                RM_HOLD: begin
                    if (!act) state_nxt = RM_IDLE;
                end
                default: begin
                    state_nxt = RM_IDLE;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_evt   <= 1'b0;
            release_o <= 1'b0;
        end else begin
            rst_evt   <= rise;
            release_o <= (state_nxt != RM_IDLE);
        end
    end

    a_r7_release_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> release_o);

    a_r7_release_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> release_o);

    a_r5_event_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |-> $past(rise));

endmodule

// File: rtl/scsi_irq_latch.sv
module scsi_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_evt,
    input  logic eop_hit,
    input  logic eop_en,
    input  logic clr,
    output logic irq
);

    logic set;

    // Reset events are never masked; new events win over clear (R8)
    assign set = rst_evt | (eop_hit & eop_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   irq <= 1'b0;
        else if (set) irq <= 1'b1;
        else if (clr) irq <= 1'b0;
    end

    a_r5_reset_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> irq);

    a_r3_eop_enabled_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_hit && eop_en) |=> irq);

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

endmodule

// File: rtl/scsi_reg_view.sv
module scsi_reg_view
    import scsi_irq_pkg::*;
(
    input  logic       eod,
    input  logic       irq,
    input  logic       dma_req,
    input  logic       parity_err,
    input  logic       phase_match,
    input  logic       busy_err,
    input  logic       atn_n,
    input  logic       ack_n,
    input  logic       bus_rst_n,
    input  logic       bsy_n,
    input  logic       req_n,
    input  logic       msg_n,
    input  logic       cd_n,
    input  logic       io_n,
    input  logic       sel_n,
    input  logic       dbp_n,
    output logic [7:0] bus_stat,
    output logic [7:0] cur_bus
);

    always_comb begin
        bus_stat            = '0;
        bus_stat[BS_EOD]    = eod;
        bus_stat[BS_DREQ]   = dma_req;
        bus_stat[BS_PERR]   = parity_err;
        bus_stat[BS_IRQ]    = irq;
        bus_stat[BS_PMATCH] = phase_match;
        bus_stat[BS_BERR]   = busy_err;
        bus_stat[BS_ATN]    = ~atn_n;
        bus_stat[BS_ACK]    = ~ack_n;
    end

    // Live view; RST is deliberately not held
    always_comb begin
        cur_bus         = '0;
        cur_bus[CB_RST] = ~bus_rst_n;
        cur_bus[CB_BSY] = ~bsy_n;
        cur_bus[CB_REQ] = ~req_n;
        cur_bus[CB_MSG] = ~msg_n;
        cur_bus[CB_CD]  = ~cd_n;
        cur_bus[CB_IO]  = ~io_n;
        cur_bus[CB_SEL] = ~sel_n;
        cur_bus[CB_DBP] = ~dbp_n;
    end

endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
    import scsi_irq_pkg::*;
#(
    parameter int OVL_CYC   = 10,
    parameter int CLEAR_CYC = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dma_mode,
    input  logic       eop_irq_en,
    input  logic       sw_rst,
    input  logic       irq_clear,
    input  logic       eop_n,
    input  logic       dack_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       bus_rst_n,
    input  logic       bsy_n,
    input  logic       req_n,
    input  logic       msg_n,
    input  logic       cd_n,
    input  logic       io_n,
    input  logic       sel_n,
    input  logic       dbp_n,
    input  logic       atn_n,
    input  logic       ack_n,
    input  logic       dma_req,
    input  logic       parity_err,
    input  logic       phase_match,
    input  logic       busy_err,
    output logic       irq,
    output logic       end_of_dma,
    output logic       bus_release,
    output logic [7:0] bus_stat,
    output logic [7:0] cur_bus
);

    logic eop_hit;
    logic rst_evt;

    scsi_eop_qual #(.OVL_CYC(OVL_CYC)) u_eop_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_mode (dma_mode),
        .eop_n    (eop_n),
        .dack_n   (dack_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .hit      (eop_hit)
    );

    scsi_rst_mon #(.CLEAR_CYC(CLEAR_CYC)) u_rst_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst_n (bus_rst_n),
        .sw_rst    (sw_rst),
        .rst_evt   (rst_evt),
        .release_o (bus_release)
    );

    scsi_irq_latch u_irq_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_evt (rst_evt),
        .eop_hit (eop_hit),
        .eop_en  (eop_irq_en),
        .clr     (irq_clear),
        .irq     (irq)
    );

    // Sticky end-of-DMA status; leaving DMA mode clears it first (R4)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        end_of_dma <= 1'b0;
        else if (!dma_mode) end_of_dma <= 1'b0;
        else if (eop_hit)  end_of_dma <= 1'b1;
    end

    scsi_reg_view u_reg_view (
        .eod         (end_of_dma),
        .irq         (irq),
        .dma_req     (dma_req),
        .parity_err  (parity_err),
        .phase_match (phase_match),
        .busy_err    (busy_err),
        .atn_n       (atn_n),
        .ack_n       (ack_n),
        .bus_rst_n   (bus_rst_n),
        .bsy_n       (bsy_n),
        .req_n       (req_n),
        .msg_n       (msg_n),
        .cd_n        (cd_n),
        .io_n        (io_n),
        .sel_n       (sel_n),
        .dbp_n       (dbp_n),
        .bus_stat    (bus_stat),
        .cur_bus     (cur_bus)
    );

    a_r4_eod_cleared_outside_dma: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> !end_of_dma);

    a_r1_eod_rises_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_of_dma) |-> $past(eop_hit));

    a_r1_eod_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_dma && dma_mode) |=> end_of_dma);

endmodule

// File: tb/scsi_irq_status_bench.sv
module scsi_irq_status_bench;

    localparam int OVL   = 10;
    localparam int CLR   = 160;
    localparam int NVEC  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_mode = 0, eop_irq_en = 0, sw_rst = 0, irq_clear = 0;
    logic eop_n = 1, dack_n = 1, rd_n = 1, wr_n = 1, bus_rst_n = 1;
    logic bsy_n = 1, req_n = 1, msg_n = 1, cd_n = 1, io_n = 1, sel_n = 1, dbp_n = 1;
    logic atn_n = 1, ack_n = 1;
    logic dma_req = 0, parity_err = 0, phase_match = 0, busy_err = 0;
    logic irq, end_of_dma, bus_release;
    logic [7:0] bus_stat, cur_bus;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scsi_irq_status u_scsi_irq_status (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .eop_irq_en(eop_irq_en),
        .sw_rst(sw_rst), .irq_clear(irq_clear), .eop_n(eop_n), .dack_n(dack_n),
        .rd_n(rd_n), .wr_n(wr_n), .bus_rst_n(bus_rst_n), .bsy_n(bsy_n),
        .req_n(req_n), .msg_n(msg_n), .cd_n(cd_n), .io_n(io_n), .sel_n(sel_n),
        .dbp_n(dbp_n), .atn_n(atn_n), .ack_n(ack_n), .dma_req(dma_req),
        .parity_err(parity_err), .phase_match(phase_match), .busy_err(busy_err),
        .irq(irq), .end_of_dma(end_of_dma), .bus_release(bus_release),
        .bus_stat(bus_stat), .cur_bus(cur_bus)
    );

    // Vector: {dma_mode, irq_en, use_wr, len[5:0], exp_eod, exp_irq}
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 1'b0, 6'd10, 1'b1, 1'b1},
        {1'b1, 1'b0, 1'b0, 6'd10, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b1, 6'd10, 1'b1, 1'b1},
        {1'b1, 1'b1, 1'b0, 6'd9,  1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 6'd12, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 6'd30, 1'b1, 1'b1},
        {1'b1, 1'b0, 1'b1, 6'd3,  1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 6'd11, 1'b1, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk) irq_clear = 1;
        @(negedge clk) irq_clear = 0;
    endtask

    task automatic overlap(input int len, input bit use_wr);
        @(negedge clk);
        eop_n = 0; dack_n = 0;
        if (use_wr) wr_n = 0; else rd_n = 0;
        cyc(len);
        eop_n = 1; dack_n = 1; rd_n = 1; wr_n = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1;
        cyc(2);
        // R11 reset state
        chk(irq == 0, "R11 irq", irq, 0);
        chk(end_of_dma == 0, "R11 end_of_dma", end_of_dma, 0);
        chk(bus_release == 0, "R11 bus_release", bus_release, 0);
        chk(bus_stat == 8'h00, "R9 idle bus_stat", bus_stat, 0);
        chk(cur_bus == 8'h00, "R10 idle cur_bus", cur_bus, 0);

        // R9 layout
        dma_req = 1; busy_err = 1; ack_n = 0; #1;
        chk(bus_stat == 8'h45, "R9 dreq/berr/ack", bus_stat, 8'h45);
        dma_req = 0; busy_err = 0; ack_n = 1;
        parity_err = 1; phase_match = 1; atn_n = 0; #1;
        chk(bus_stat == 8'h2A, "R9 perr/pmatch/atn", bus_stat, 8'h2A);
        parity_err = 0; phase_match = 0; atn_n = 1;

        // R10 layout
        bsy_n = 0; msg_n = 0; io_n = 0; dbp_n = 0; #1;
        chk(cur_bus == 8'h55, "R10 bsy/msg/io/dbp", cur_bus, 8'h55);
        bsy_n = 1; msg_n = 1; io_n = 1; dbp_n = 1;
        req_n = 0; cd_n = 0; sel_n = 0; #1;
        chk(cur_bus == 8'h2A, "R10 req/cd/sel", cur_bus, 8'h2A);
        req_n = 1; cd_n = 1; sel_n = 1;
        @(negedge clk) bus_rst_n = 0; #1;
        chk(cur_bus == 8'h80, "R10 rst live set", cur_bus, 8'h80);
        @(negedge clk) bus_rst_n = 1; #1;
        chk(cur_bus == 8'h00, "R10 rst not latched", cur_bus, 0);
        cyc(CLR + 10);
        clear_irq();
        cyc(1);

        // Vector table for end-of-process qualification (R1, R2, R3, R4)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk) dma_mode = 0;
            cyc(2);
            chk(end_of_dma == 0, "R4 cleared outside DMA", end_of_dma, 0);
            clear_irq();
            @(negedge clk);
            dma_mode   = VEC[i][10];
            eop_irq_en = VEC[i][9];
            overlap(int'(VEC[i][7:2]), VEC[i][8]);
            cyc(3);
            chk(end_of_dma == VEC[i][1], $sformatf("R1/R2 vec %0d end_of_dma", i),
                end_of_dma, VEC[i][1]);
            chk(irq == VEC[i][0], $sformatf("R3 vec %0d irq", i), irq, VEC[i][0]);
        end
        chk(bus_stat[7] == end_of_dma, "R9 eod bit", bus_stat[7], end_of_dma);
        chk(bus_stat[4] == irq, "R9 irq bit", bus_stat[4], irq);

        // R12 split overlap does not accumulate
        @(negedge clk) dma_mode = 0;
        clear_irq();
        @(negedge clk) dma_mode = 1; eop_irq_en = 1;
        overlap(6, 0);
        overlap(6, 0);
        cyc(3);
        chk(end_of_dma == 0, "R12 split overlap", end_of_dma, 0);
        chk(irq == 0, "R12 split overlap irq", irq, 0);

        // R5 unmasked bus reset, R7 held reset
        @(negedge clk) eop_irq_en = 0; dma_mode = 0; bus_rst_n = 0;
        cyc(1);
        chk(bus_release == 1, "R7 release on edge", bus_release, 1);
        cyc(1);
        chk(irq == 1, "R5 bus reset irq unmasked", irq, 1);
        cyc(300);
        chk(bus_release == 1, "R7 release while held", bus_release, 1);
        chk(irq == 1, "R8 irq sticky", irq, 1);
        bus_rst_n = 1;
        cyc(2);
        chk(bus_release == 0, "R7 release drops", bus_release, 0);
        clear_irq();
        cyc(1);
        chk(irq == 0, "R8 clear", irq, 0);

        // R7 short pulse keeps release for the bus-clear interval
        @(negedge clk) bus_rst_n = 0;
        cyc(2);
        bus_rst_n = 1;
        cyc(100);
        chk(bus_release == 1, "R7 min interval", bus_release, 1);
        cyc(100);
        chk(bus_release == 0, "R7 after interval", bus_release, 0);
        clear_irq();
        cyc(1);

        // R6 software reset bit
        @(negedge clk) sw_rst = 1;
        cyc(2);
        chk(irq == 1, "R6 sw reset irq", irq, 1);
        chk(bus_release == 1, "R7 sw release", bus_release, 1);
        @(negedge clk) sw_rst = 0;
        cyc(CLR + 5);
        chk(bus_release == 0, "R7 sw release ends", bus_release, 0);
        clear_irq();
        cyc(1);
        chk(irq == 0, "R8 cleared before race", irq, 0);

        // R8 new source wins over simultaneous clear
        @(negedge clk) sw_rst = 1;
        @(negedge clk) irq_clear = 1;
        @(negedge clk) irq_clear = 0;
        chk(irq == 1, "R8 set wins over clear", irq, 1);
        sw_rst = 0;
        cyc(CLR + 5);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule